// File: doc/BRIEF.md
# Bridge Window Address Translation Registers

This block is the control-register slice of a bus bridge. Software sees eight 32-bit registers: three window map registers, three auxiliary map registers, one identity register and one flag register. The window map registers set where each of three host-side memory windows lands on the target bus. From each window map register the block keeps a registered window base address. Any host offset inside window i is translated to a target address by combining that base with the low offset bits.

A parameter picks one of two board variants. In variant 0 the low nibble of a map register becomes target address bits [31:28]. In variant 1 the whole register is used, with the bits below the window's power-of-two size masked off. Each variant has its own fixed set of three window sizes. The translation port is purely combinational. Register reads return one cycle after the request.

Top module: `bwin_xlate_regs`

## Requirements
- R1: Register offsets are fixed: window maps 0, 1 and 2 at 0x00, 0x04 and 0x08, identity at 0x0C, flags at 0x10, and auxiliary maps 0, 1 and 2 at 0x14, 0x18 and 0x1C. A full write to any of them reads back unchanged.
- R2: A read request is answered on `rd_data` with `rd_valid` high for exactly one cycle, in the cycle after the request.
- R3: A read whose offset is not word aligned (bits [1:0] not 00), or whose offset is 0x20 or above, returns zero.
- R4: A write to such an unmapped offset changes no register, and `wr_err` is high for exactly the next cycle.
- R5: Only accesses with all four byte enables set (`byte_en` = 4'hF) are valid. A write with any other value changes nothing and raises `wr_err` for one cycle. A read with any other value returns zero.
- R6: In variant 0 the base of window i is map register i bits [3:0] placed at address bits [31:28], with zeros below. The window sizes are 0x0C000000, 0x10000000 and 0x10000000.
- R7: In variant 1 the base of window i is map register i AND NOT (size_i - 1). The window sizes are 0x01000000, 0x04000000 and 0x08000000.
- R8: The base on `win_base` (window i at bits [32*i+31:32*i]) changes in the cycle after a write to map register i. Writes to the identity, flag or auxiliary registers leave all bases unchanged.
- R9: For window index `xl_win` from 0 to 2, `xl_addr` equals base OR (`xl_ofs` AND (size - 1)). It is combinational.
- R10: `xl_hit` is high only when `xl_win` is below 3 and `xl_ofs` is below the window size. For `xl_win` = 3, `xl_addr` is zero.
- R11: A synchronous active-low reset clears all eight registers and all three bases to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | OFS_W | Byte offset within the register region |
| byte_en | input | 4 | Byte enables; only 4'hF is a valid access |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid strobe |
| wr_err | output | 1 | One-cycle strobe for a rejected write |
| win_base | output | 96 | Registered bases of the three windows |
| xl_win | input | 2 | Window index to translate through |
| xl_ofs | input | 32 | Host offset within the window |
| xl_addr | output | 32 | Translated target address |
| xl_hit | output | 1 | Offset lies inside the selected window |

## Verification
A stale or corrupted map register shows up on `win_base` in the cycle after the write. It also shows up at once on `xl_addr`, because translation has no register of its own. A wrong decode of the register offset shows up on the read data one cycle after the read request: either the wrong register answers, or an unmapped offset returns data that is not zero. A missed or stretched error strobe is visible on `wr_err` in the single cycle after the write, so that cycle is sampled directly. Both variants run side by side, so a mix-up of the size or mask tables gives different bases for the same written value.

// File: rtl/bwx_pkg.sv
// Package: shared constants and per-variant window math for the bridge
// window translation block. Assumes exactly three memory windows.
package bwx_pkg;
    localparam int NUM_WIN = 3;
    localparam int AW      = 32;
    localparam int NUM_REG = 8;

    // Register slot index, decoded from addr[4:2]; the order is the register map.
    typedef enum logic [2:0] {
        RI_WMAP0 = 3'd0,
        RI_WMAP1 = 3'd1,
        RI_WMAP2 = 3'd2,
        RI_IDENT = 3'd3,
        RI_FLAGS = 3'd4,
        RI_AUX0  = 3'd5,
        RI_AUX1  = 3'd6,
        RI_AUX2  = 3'd7
    } reg_idx_e;

    // Window size in bytes for a given variant and window index.
    function automatic logic [AW-1:0] win_size(input int variant, input int idx);
        logic [AW-1:0] s;
        if (variant == 0) begin
            s = (idx == 0) ? 32'h0C00_0000 : 32'h1000_0000;
        end else begin
            case (idx)
                0:       s = 32'h0100_0000;
                1:       s = 32'h0400_0000;
                default: s = 32'h0800_0000;
            endcase
        end
        return s;
    endfunction

    // Window base derived from a map register value.
    function automatic logic [AW-1:0] base_of(input int variant, input int idx,
                                              input logic [AW-1:0] m);
        logic [AW-1:0] b;
        if (variant == 0) begin
            b = {m[3:0], 28'h000_0000};
        end else begin
            b = m & ~(win_size(variant, idx) - 32'd1);
        end
        return b;
    endfunction
endpackage

// File: rtl/bwx_regfile.sv
// Module: register storage, offset decode, read path and write-error strobe.
// Assumes only 32-bit accesses (byte_en all ones) are legal; others are rejected.
module bwx_regfile
    import bwx_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [OFS_W-1:0]   addr,
    input  logic [3:0]         byte_en,
    input  logic [AW-1:0]      wdata,
    output logic [AW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               wr_err,
    output logic [NUM_WIN-1:0] map_wr
);
    logic [AW-1:0] regs_q [NUM_REG];
    logic          in_range;
    logic          full_acc;
    logic          acc_ok;
    reg_idx_e      slot;

    // Decode: word aligned, below 0x20, full width.
    always_comb begin
        in_range = (addr[1:0] == 2'b00) && (addr[OFS_W-1:5] == '0);
        full_acc = (byte_en == 4'hF);
        acc_ok   = in_range && full_acc;
        slot     = reg_idx_e'(addr[4:2]);
    end

    // Strobes for the base calculator, one per window map register.
    always_comb begin
        map_wr = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            map_wr[w] = wr_en && acc_ok && (slot == reg_idx_e'(w));
        end
    end

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REG; r++) regs_q[r] <= '0;
        end else if (wr_en && acc_ok) begin
            regs_q[slot] <= wdata;
        end
    end

    // Registered read response; zero on an invalid access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= (rd_en && acc_ok) ? regs_q[slot] : '0;
        end
    end

    // One-cycle error strobe for a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en && !acc_ok;
    end
endmodule

// File: rtl/bwx_base_calc.sv
// Module: keeps one registered base per window, loaded on a map register write.
// Assumes map_wr is one-hot or zero and qualified by the register decode.
module bwx_base_calc
    import bwx_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_WIN-1:0]    map_wr,
    input  logic [AW-1:0]         wdata,
    output logic [NUM_WIN*AW-1:0] win_base
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [AW-1:0] base_q;
        // Load the window base from the write data through the variant mapping.
        always_ff @(posedge clk) begin
            if (!rst_n)         base_q <= base_of(VARIANT, g, '0);
            else if (map_wr[g]) base_q <= base_of(VARIANT, g, wdata);
        end
        assign win_base[g*AW +: AW] = base_q;
    end
endmodule

// File: rtl/bwx_xlate.sv
// Module: combinational host-offset to target-address translation.
// Assumes the window index selects 0..2; index 3 yields no hit and zero address.
module bwx_xlate
    import bwx_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [NUM_WIN*AW-1:0] win_base,
    input  logic [1:0]            xl_win,
    input  logic [AW-1:0]         xl_ofs,
    output logic [AW-1:0]         xl_addr,
    output logic                  xl_hit
);
    // Select the window and merge base with the masked offset.
    always_comb begin
        xl_addr = '0;
        xl_hit  = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (xl_win == 2'(w)) begin
                xl_addr = win_base[w*AW +: AW] | (xl_ofs & (win_size(VARIANT, w) - 32'd1));
                xl_hit  = (xl_ofs < win_size(VARIANT, w));
            end
        end
    end
endmodule

// File: rtl/bwin_xlate_regs.sv
// Module: top of the bridge window translation register block.
// Assumes a single register master; VARIANT 0 = nibble map, 1 = masked map.
module bwin_xlate_regs
    import bwx_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int VARIANT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OFS_W-1:0]      addr,
    input  logic [3:0]            byte_en,
    input  logic [AW-1:0]         wdata,
    output logic [AW-1:0]         rd_data,
    output logic                  rd_valid,
    output logic                  wr_err,
    output logic [NUM_WIN*AW-1:0] win_base,
    input  logic [1:0]            xl_win,
    input  logic [AW-1:0]         xl_ofs,
    output logic [AW-1:0]         xl_addr,
    output logic                  xl_hit
);
    logic [NUM_WIN-1:0] map_wr;

    bwx_regfile #(.OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_err(wr_err), .map_wr(map_wr)
    );

    bwx_base_calc #(.VARIANT(VARIANT)) u_base (
        .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .wdata(wdata), .win_base(win_base)
    );

    bwx_xlate #(.VARIANT(VARIANT)) u_xl (
        .win_base(win_base), .xl_win(xl_win), .xl_ofs(xl_ofs),
        .xl_addr(xl_addr), .xl_hit(xl_hit)
    );
endmodule

// File: rtl/bwx_chk.sv
// Module: assertion checker bound to bwin_xlate_regs; observes ports only.
module bwx_chk
    import bwx_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [OFS_W-1:0]      addr,
    input logic [3:0]            byte_en,
    input logic [AW-1:0]         rd_data,
    input logic                  rd_valid,
    input logic                  wr_err,
    input logic [NUM_WIN*AW-1:0] win_base,
    input logic [1:0]            xl_win,
    input logic                  xl_hit,
    input logic [AW-1:0]         xl_addr
);
    logic bad_acc;
    assign bad_acc = (addr[1:0] != 2'b00) || (addr[OFS_W-1:5] != '0) || (byte_en != 4'hF);

    // R2
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R2
    rd_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R3
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bad_acc) |=> (rd_data == '0));
    // R4
    bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_acc) |=> wr_err);
    // R4
    err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);
    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(win_base));
    // R10
    no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_win == 2'd3) |-> (!xl_hit && xl_addr == '0));
endmodule

bind bwin_xlate_regs bwx_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .byte_en(byte_en), .rd_data(rd_data), .rd_valid(rd_valid), .wr_err(wr_err),
    .win_base(win_base), .xl_win(xl_win), .xl_hit(xl_hit), .xl_addr(xl_addr)
);

// File: tb/sim_bwin_xlate_regs.sv
`timescale 1ns/1ps
module sim_bwin_xlate_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  byte_en = 4'hF;
    logic [31:0] wdata = '0;
    logic [1:0]  xl_win = '0;
    logic [31:0] xl_ofs = '0;
    logic [31:0] rd0, rd1, xa0, xa1;
    logic        rv0, rv1, we0, we1, xh0, xh1;
    logic [95:0] wb0, wb1;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    bwin_xlate_regs #(.OFS_W(12), .VARIANT(0)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rd_data(rd0), .rd_valid(rv0), .wr_err(we0),
        .win_base(wb0), .xl_win(xl_win), .xl_ofs(xl_ofs), .xl_addr(xa0), .xl_hit(xh0));
    bwin_xlate_regs #(.OFS_W(12), .VARIANT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rd_data(rd1), .rd_valid(rv1), .wr_err(we1),
        .win_base(wb1), .xl_win(xl_win), .xl_ofs(xl_ofs), .xl_addr(xa1), .xl_hit(xh1));

    function automatic logic [31:0] e_size(int v, int i);
        if (v == 0) return (i == 0) ? 32'h0C00_0000 : 32'h1000_0000;
        return (i == 0) ? 32'h0100_0000 : (i == 1) ? 32'h0400_0000 : 32'h0800_0000;
    endfunction
    function automatic logic [31:0] e_base(int v, int i, logic [31:0] m);
        if (v == 0) return m << 28;
        return m & ~(e_size(v, i) - 1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; byte_en = be;
        @(negedge clk);
        wr_en = 1'b0; byte_en = 4'hF;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        rd_en = 1'b1; addr = a; byte_en = be;
        @(negedge clk);
        rd_en = 1'b0; byte_en = 4'hF;
        chk("R2 valid", {30'b0, rv0, rv1}, 32'h3);
        d0 = rd0; d1 = rd1;
        @(negedge clk);
        chk("R2 single", {30'b0, rv0, rv1}, 32'h0);
    endtask

    task automatic t_reset_state;
        logic [31:0] a, b;
        for (int r = 0; r < 8; r++) begin
            rd(12'(r * 4), a, b);
            chk("R11 reg v0", a, 0); chk("R11 reg v1", b, 0);
        end
        chk("R11 base v0", wb0[31:0] | wb0[63:32] | wb0[95:64], 0);
        chk("R11 base v1", wb1[31:0] | wb1[63:32] | wb1[95:64], 0);
    endtask

    task automatic t_readback;
        logic [31:0] a, b;
        for (int r = 0; r < 8; r++) wr(12'(r * 4), 32'hA500_0000 + 32'(r * 32'h0111_1111));
        for (int r = 0; r < 8; r++) begin
            rd(12'(r * 4), a, b);
            chk("R1 readback", a, 32'hA500_0000 + 32'(r * 32'h0111_1111));
            chk("R1 readback v1", b, 32'hA500_0000 + 32'(r * 32'h0111_1111));
        end
    endtask

    task automatic t_bases;
        logic [31:0] m;
        for (int i = 0; i < 3; i++) begin
            m = 32'hFFFF_FFF5 - 32'(i * 32'h0123_4567);
            wr(12'(i * 4), m);
            chk("R6 base v0", wb0[i*32 +: 32], e_base(0, i, m));
            chk("R7 base v1", wb1[i*32 +: 32], e_base(1, i, m));
        end
    endtask

    task automatic t_other_regs;
        logic [95:0] s0, s1;
        s0 = wb0; s1 = wb1;
        wr(12'h00C, 32'h1234_5678);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h014, 32'h0000_000A);
        wr(12'h01C, 32'h8000_0000);
        chk("R8 no change v0 w0", wb0[31:0], s0[31:0]);
        chk("R8 no change v0 w2", wb0[95:64], s0[95:64]);
        chk("R8 no change v1 w1", wb1[63:32], s1[63:32]);
    endtask

    task automatic t_unmapped;
        logic [31:0] a, b;
        rd(12'h020, a, b); chk("R3 high ofs", a | b, 0);
        rd(12'h002, a, b); chk("R3 unaligned", a | b, 0);
        @(negedge clk); wr_en = 1'b1; addr = 12'h024; wdata = 32'hDEAD_BEEF;
        @(negedge clk); wr_en = 1'b0;
        chk("R4 err", {31'b0, we0 & we1}, 1);
        @(negedge clk);
        chk("R4 err one cycle", {31'b0, we0 | we1}, 0);
        wr(12'h001, 32'hDEAD_BEEF);
        rd(12'h000, a, b); chk("R4 map0 kept", a, 32'hFFFF_FFF5);
        rd(12'h004, a, b); chk("R4 map1 kept", a, 32'hFFFF_FFF5 - 32'h0123_4567);
    endtask

    task automatic t_partial;
        logic [31:0] a, b;
        logic [31:0] old;
        old = wb0[31:0];
        @(negedge clk); wr_en = 1'b1; addr = 12'h000; wdata = 32'h0000_0003; byte_en = 4'h1;
        @(negedge clk); wr_en = 1'b0; byte_en = 4'hF;
        chk("R5 err", {31'b0, we0 & we1}, 1);
        chk("R5 base kept", wb0[31:0], old);
        rd(12'h000, a, b, 4'h3); chk("R5 partial read", a | b, 0);
        rd(12'h000, a, b); chk("R5 reg kept", a, 32'hFFFF_FFF5);
    endtask

    task automatic t_xlate;
        logic [31:0] b0, b1, o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            o = 32'h0234_5678 + 32'(i);
            xl_win = 2'(i); xl_ofs = o;
            #1;
            b0 = wb0[i*32 +: 32]; b1 = wb1[i*32 +: 32];
            chk("R9 addr v0", xa0, b0 | (o & (e_size(0, i) - 1)));
            chk("R9 addr v1", xa1, b1 | (o & (e_size(1, i) - 1)));
            chk("R10 hit v0", {31'b0, xh0}, {31'b0, o < e_size(0, i)});
            chk("R10 hit v1", {31'b0, xh1}, {31'b0, o < e_size(1, i)});
        end
        @(negedge clk); xl_win = 2'd0; xl_ofs = 32'h0C00_0000; #1;
        chk("R10 edge miss v0", {31'b0, xh0}, 0);
        xl_ofs = 32'h0BFF_FFFF; #1;
        chk("R10 edge hit v0", {31'b0, xh0}, 1);
        xl_win = 2'd3; #1;
        chk("R10 idx3", {xa0[31:1] | xa1[31:1], xh0 | xh1}, 0);
    endtask

    task automatic t_reset_again;
        logic [31:0] a, b;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 base after reset", wb0[31:0] | wb1[95:64], 0);
        rd(12'h014, a, b); chk("R11 aux after reset", a | b, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_readback();
        t_bases();
        t_other_regs();
        t_unmapped();
        t_partial();
        t_xlate();
        t_reset_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule